// File: doc/BRIEF.md
# Selectless Synchronous Serial Port

This block is an eight-bit synchronous serial port with no chip-select line. One shift register serves both directions. Its final stage feeds the serial data output, and bits from the serial data input enter at the opposite end. A transfer is framed only by counting serial clock edges. The clock rests high. A falling edge presents the next outgoing bit, and a rising edge samples the incoming bit. The eighth rising edge closes the transfer.

The role is set by configuration inputs and not by any pin. As master, the block divides its system clock to make the serial clock. One of four rates is chosen, and writing a byte while the port is idle starts a transfer. As slave, it takes the serial clock from outside. That clock passes through a two-flop synchroniser, and its edges are found from the synchronised samples. Software loads the outgoing byte through a write strobe and reads the shift register as the received byte. A completion flag and a write-collision flag report status. While the port is disabled, the data output follows a preset level supplied from a general-purpose output bit.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, sckOut is 1, doneFlag and collFlag are 0 and rxData is 0. sckOut is 1 at all times when no master transfer is running.
- R2: While cfgEnable is 0, sdo equals presetLevel, and a write starts no transfer. After enabling, sdo keeps that level until the first falling serial clock edge.
- R3: With cfgEnable=1 and cfgMaster=1, a txWrite while idle loads txData and starts a transfer. sdo changes only on the 8 falling edges of sckOut, and each falling edge presents the next transmit bit.
- R4: sdi is sampled on each rising serial clock edge. After the eighth rising edge, rxData holds the 8 received bits.
- R5: cfgLsbFirst=0 sends and receives bit 7 first. cfgLsbFirst=1 sends and receives bit 0 first.
- R6: cfgRate values 0, 1, 2 and 3 give master clock divisors of 2, 4, 16 and 32. doneFlag is first seen 8×divisor system clocks after the clock edge that accepted the write.
- R7: doneFlag is set only on the eighth rising edge of a transfer. A rxRead pulse while idle clears both doneFlag and collFlag.
- R8: A txWrite during a transfer is ignored, so the transmitted and received bytes are unchanged, and it sets collFlag.
- R9: With cfgMaster=0, sckOut stays 1 and a write does not start a transfer. Edges on sckIn, seen within three system clocks, frame the transfer with the same bit timing and ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Port enable |
| cfgMaster | input | 1 | 1 = master (internal clock), 0 = slave |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| cfgRate | input | 2 | Master divisor select: 2, 4, 16, 32 |
| presetLevel | input | 1 | Level driven on sdo while disabled |
| txWrite | input | 1 | Write strobe for the transmit byte |
| txData | input | 8 | Transmit byte |
| rxRead | input | 1 | Read strobe, clears flags |
| rxData | output | 8 | Shift register contents / received byte |
| doneFlag | output | 1 | Transfer complete |
| collFlag | output | 1 | Write collision |
| sckIn | input | 1 | External serial clock (slave) |
| sckOut | output | 1 | Generated serial clock (master), idle high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Five properties are checked on every cycle:
- the serial clock is high whenever the port is idle;
- a write during a transfer raises the collision flag;
- the completion flag rises only when the busy state ends;
- a read while idle clears the completion flag;
- the output bit holds still between falling edges.

Only the bench's scenarios can show bit order in both directions, the exact divisor of each rate, received byte values, the preset level across enabling, and slave framing through the synchroniser.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic load;
    logic fall;
    logic rise;
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HALF_R0 = 1,
  parameter int HALF_R1 = 2,
  parameter int HALF_R2 = 8,
  parameter int HALF_R3 = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic       cfgMaster,
  input  logic [1:0] cfgRate,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       sckIn,
  output sspStrobe_t strobe,
  output logic       busy,
  output logic       sckOut,
  output logic       doneFlag,
  output logic       collFlag
);
  // HALF_R3 is the largest half period and sizes the divider counter
  localparam int CNT_W = $clog2(HALF_R3 + 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] divCnt, halfSel;
  logic [BIT_W-1:0] bitCnt;
  logic sckInt, syncA, syncB, syncC;
  logic tick, extFall, extRise, slaveOn, masterStart, slaveStart, lastRise;

  always_comb begin
    case (cfgRate)
      2'd0:    halfSel = CNT_W'(HALF_R0);
      2'd1:    halfSel = CNT_W'(HALF_R1);
      2'd2:    halfSel = CNT_W'(HALF_R2);
      default: halfSel = CNT_W'(HALF_R3);
    endcase
  end

  assign tick        = busy && cfgMaster && (divCnt == halfSel - CNT_W'(1));
  assign extFall     = syncC && !syncB;
  assign extRise     = !syncC && syncB;
  assign slaveOn     = cfgEnable && !cfgMaster;
  assign masterStart = txWrite && !busy && cfgEnable && cfgMaster;
  assign slaveStart  = slaveOn && !busy && extFall;

  always_comb begin
    strobe.load = txWrite && !busy;
    strobe.fall = (tick && sckInt) || (slaveOn && extFall);
    strobe.rise = (tick && !sckInt) || (slaveOn && busy && extRise);
  end

  assign lastRise = strobe.rise && (bitCnt == BIT_W'(DATA_W - 1));
  assign sckOut   = sckInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      syncC <= 1'b1;
    end else begin
      syncA <= sckIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sckInt <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!cfgEnable) begin
      busy   <= 1'b0;
      sckInt <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!busy) begin
      busy   <= masterStart || slaveStart;
      sckInt <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      if (lastRise) busy <= 1'b0;
      if (tick) sckInt <= !sckInt;
      if (cfgMaster) divCnt <= tick ? '0 : divCnt + CNT_W'(1);
      if (strobe.rise) bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
    end else begin
      if (lastRise) doneFlag <= 1'b1;
      else if (rxRead) doneFlag <= 1'b0;
      if (txWrite && busy) collFlag <= 1'b1;
      else if (rxRead) collFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        strobe,
  input  logic              cfgEnable,
  input  logic              cfgLsbFirst,
  input  logic              presetLevel,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  output logic [DATA_W-1:0] rxData,
  output logic              sdo
);
  logic [DATA_W-1:0] shReg;
  logic sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= txData;
    end else if (strobe.rise) begin
      shReg <= cfgLsbFirst ? {sdi, shReg[DATA_W-1:1]} : {shReg[DATA_W-2:0], sdi};
    end
  end

  // while disabled the output stage tracks the preset so enabling is glitch free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdoReg <= 1'b0;
    else if (!cfgEnable) sdoReg <= presetLevel;
    else if (strobe.fall) sdoReg <= cfgLsbFirst ? shReg[0] : shReg[DATA_W-1];
  end

  assign sdo    = cfgEnable ? sdoReg : presetLevel;
  assign rxData = shReg;
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HALF_R0 = 1,
  parameter int HALF_R1 = 2,
  parameter int HALF_R2 = 8,
  parameter int HALF_R3 = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic              cfgLsbFirst,
  input  logic [1:0]        cfgRate,
  input  logic              presetLevel,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              collFlag,
  input  logic              sckIn,
  output logic              sckOut,
  input  logic              sdi,
  output logic              sdo
);
  sspStrobe_t strobe;
  logic busy;

  ssp_ctrl #(
    .DATA_W(DATA_W), .HALF_R0(HALF_R0), .HALF_R1(HALF_R1),
    .HALF_R2(HALF_R2), .HALF_R3(HALF_R3)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgRate(cfgRate), .txWrite(txWrite), .rxRead(rxRead), .sckIn(sckIn),
    .strobe(strobe), .busy(busy), .sckOut(sckOut),
    .doneFlag(doneFlag), .collFlag(collFlag)
  );

  ssp_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgEnable(cfgEnable),
    .cfgLsbFirst(cfgLsbFirst), .presetLevel(presetLevel), .txData(txData),
    .sdi(sdi), .rxData(rxData), .sdo(sdo)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
  import ssp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgEnable,
  input logic       txWrite,
  input logic       rxRead,
  input logic       busy,
  input sspStrobe_t strobe,
  input logic       sckOut,
  input logic       sdo,
  input logic       doneFlag,
  input logic       collFlag
);
  // R1
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut);

  // R8
  write_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && busy) |=> collFlag);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $fell(busy));

  // R7
  read_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !busy) |=> !doneFlag);

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && $past(cfgEnable) && !$past(strobe.fall)) |-> $stable(sdo));
endmodule

bind serial_shift_port ssp_checker chk_i (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .txWrite(txWrite),
  .rxRead(rxRead), .busy(busy), .strobe(strobe), .sckOut(sckOut),
  .sdo(sdo), .doneFlag(doneFlag), .collFlag(collFlag)
);

// File: tb/serial_shift_port_tb_top.sv
module serial_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {rate[1:0], lsbFirst, txByte[7:0], rxByte[7:0]}
  localparam logic [18:0] VECS [NVEC] = '{
    {2'd0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 1'b1, 8'h81, 8'h7E},
    {2'd2, 1'b0, 8'h0F, 8'hF0},
    {2'd3, 1'b1, 8'hC3, 8'h96},
    {2'd0, 1'b1, 8'h01, 8'h80},
    {2'd1, 1'b0, 8'hFF, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgMaster = 1'b1, cfgLsbFirst = 1'b0;
  logic [1:0] cfgRate = 2'd0;
  logic presetLevel = 1'b1, txWrite = 1'b0, rxRead = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [7:0] rxData;
  logic doneFlag, collFlag, sckIn = 1'b1, sckOut, sdi = 1'b0, sdo;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = !clk;

  serial_shift_port dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgLsbFirst(cfgLsbFirst), .cfgRate(cfgRate), .presetLevel(presetLevel),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .rxData(rxData),
    .doneFlag(doneFlag), .collFlag(collFlag), .sckIn(sckIn), .sckOut(sckOut),
    .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readFlags();
    @(negedge clk) rxRead = 1'b1;
    @(negedge clk) rxRead = 1'b0;
    chk("R7 read clears done", doneFlag, 0);
    chk("R7 read clears collision", collFlag, 0);
  endtask

  // bench acts as remote slave: drives sdi after each fall, captures sdo
  task automatic masterXfer(input logic [1:0] rate, input logic lsb,
                            input logic [7:0] tx, input logic [7:0] rx,
                            input int collideAt);
    logic [7:0] cap = 8'h00;
    logic prev = 1'b1;
    int k = 0;
    int cyc = 0;
    cfgMaster = 1'b1; cfgRate = rate; cfgLsbFirst = lsb;
    @(negedge clk) txData = tx; txWrite = 1'b1;
    @(negedge clk) txWrite = 1'b0;
    forever begin
      if (prev && !sckOut) begin
        cap = lsb ? {sdo, cap[7:1]} : {cap[6:0], sdo};
        sdi = lsb ? rx[k] : rx[7-k];
        k++;
      end
      prev = sckOut;
      if (doneFlag || cyc > 4000) break;
      @(negedge clk);
      cyc++;
      if (collideAt != 0 && cyc == collideAt) begin txData = 8'h00; txWrite = 1'b1; end
      else txWrite = 1'b0;
    end
    txWrite = 1'b0;
    chk("R6 done latency 8*divisor", cyc, 8 * (rate == 0 ? 2 : rate == 1 ? 4 : rate == 2 ? 16 : 32));
    chk("R3 R5 transmitted bits in order", cap, tx);
    chk("R4 R5 received byte", rxData, rx);
    chk("R3 eight falling edges", k, 8);
    chk("R7 done set at end", doneFlag, 1);
    if (collideAt != 0) chk("R8 collision flag", collFlag, 1);
  endtask

  task automatic slaveXfer(input logic lsb, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] cap = 8'h00;
    cfgMaster = 1'b0; cfgLsbFirst = lsb;
    @(negedge clk) txData = tx; txWrite = 1'b1;
    @(negedge clk) txWrite = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 sckOut quiet in slave", sckOut, 1);
    chk("R9 write alone does not start", doneFlag, 0);
    for (int k = 0; k < 8; k++) begin
      sckIn = 1'b0;
      sdi = lsb ? rx[k] : rx[7-k];
      repeat (4) @(negedge clk);
      cap = lsb ? {sdo, cap[7:1]} : {cap[6:0], sdo};
      sckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk("R9 slave transmitted bits", cap, tx);
    chk("R9 slave received byte", rxData, rx);
    chk("R9 slave done", doneFlag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset sckOut", sckOut, 1);
    chk("R1 reset done", doneFlag, 0);
    chk("R1 reset collision", collFlag, 0);
    chk("R1 reset rxData", rxData, 0);
    chk("R2 disabled sdo preset 1", sdo, 1);
    presetLevel = 1'b0;
    @(negedge clk);
    chk("R2 disabled sdo preset 0", sdo, 0);
    @(negedge clk) txData = 8'hFF; txWrite = 1'b1;
    @(negedge clk) txWrite = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 disabled write starts nothing", sckOut, 1);
    chk("R2 disabled no done", doneFlag, 0);
    presetLevel = 1'b1;
    @(negedge clk) cfgEnable = 1'b1;
    @(negedge clk) presetLevel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 preset level kept after enable", sdo, 1);

    for (int i = 0; i < NVEC; i++) begin
      masterXfer(VECS[i][18:17], VECS[i][16], VECS[i][15:8], VECS[i][7:0], 0);
      readFlags();
    end

    masterXfer(2'd3, 1'b0, 8'h5A, 8'hC6, 40);
    readFlags();

    slaveXfer(1'b0, 8'hB4, 8'h2D);
    readFlags();
    slaveXfer(1'b1, 8'h39, 8'hE1);
    readFlags();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule